// File: doc/BRIEF.md
# Protected Register Access Arbiter

This block decides the fate of one read or write request aimed at a single protected system register. From the requester's privilege level (0 to 3), the direction of the access, the straps that say which levels and features exist, and a set of live control bits owned by levels 2 and 3 and by the debug logic, it picks one of five results. The result is permit, undefined instruction, trap to level 2, trap to level 3 or debug halt. A fixed, level-specific priority chain produces the decision, and an early-undefined mode moves some level-3 conditions ahead of the other checks.

The decision is registered. One clock after a request is presented, `rsp_valid` pulses together with a one-hot result and a 6-bit exception class. Performing the register transfer itself is the caller's job. The asynchronous reset is synchronised internally before it is released.

Top module: `sysreg_access_arbiter`

## Requirements
- R1: A request at privilege level 0 always produces the undefined result, whatever the control inputs are.
- R2: A request sampled on a clock edge is answered on the next edge with `rsp_valid`=1. In a cycle with no request answered, `rsp_valid`=0 and `rsp_outcome` and `rsp_class` are all zero.
- R3: `rsp_outcome` is one-hot. Bit 0 is permit, bit 1 is undefined, bit 2 is trap to level 2, bit 3 is trap to level 3 and bit 4 is debug halt. Exactly one bit is set when `rsp_valid`=1.
- R4: `rsp_class` is 0x18 whenever the result is a trap to level 2 or to level 3. Otherwise it is 0.
- R5: An owner mismatch exists when `l3_owner[0]`=0, or when `l3_owner[1]` differs from `cur_ns`, or when `strap_realm`=1 and `l3_realm_owner` differs from `cur_realm`. It only counts when `strap_el3`=1.
- R6: At level 1 the checks run in this order. First comes undefined for a disabled trace enable, then undefined for an owner mismatch; these two apply only while `sdd_early`=1. Next comes the fine-grained trap to level 2, then the level-2 trap (`strap_el2_on`=1 and `l2_own_lo`=0). After that come the level-3 trap for a disabled trace enable, then the level-3 trap for a mismatch, then halt. If none applies, the access is permitted.
- R7: The fine-grained trap requires `strap_el2_on`=1 and `strap_fgt`=1. It is then raised when `strap_el3`=1 with `l3_fgt_en`=0, or when the access's own allow bit is 0. Reads use `fgt_rd_ok` and writes use `fgt_wr_ok`.
- R8: At level 2 the owner-mismatch check comes before the trace-enable check, in the early-undefined stage and in the trap stage alike. No trap to level 2 is ever produced from level 2.
- R9: Any level-3 trap becomes undefined while `sdd_undef`=1. Level-3 conditions only apply when `strap_el3`=1.
- R10: Halt requires `strap_ext_trace`=1, `os_lock`=0, `halt_ok`=1 and `trace_acc_trap`=1. At levels 2 and 3 it also requires `el1_narrow`=0.
- R11: At level 3 the only possible results are halt (R10) and permit.
- R12: While reset is asserted, and until the synchronised reset releases, `rsp_valid`, `rsp_outcome` and `rsp_class` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_el | input | 2 | Privilege level of the requester |
| strap_el3 | input | 1 | Level 3 implemented |
| strap_el2_on | input | 1 | Level 2 implemented and enabled |
| strap_fgt | input | 1 | Fine-grained trap feature present |
| strap_realm | input | 1 | Realm management present |
| strap_ext_trace | input | 1 | External trace-buffer mode supported |
| sdd_early | input | 1 | Early-undefined priority mode active |
| sdd_undef | input | 1 | Level-3 traps are turned into undefined |
| l3_trace_en | input | 1 | Level-3 trace-buffer access enable |
| l3_owner | input | 2 | Level-3 trace-buffer ownership field |
| l3_realm_owner | input | 1 | Level-3 realm ownership bit |
| cur_ns | input | 1 | Current non-secure state bit |
| cur_realm | input | 1 | Current realm state bit |
| l3_fgt_en | input | 1 | Level-3 enable of the fine-grained trap controls |
| fgt_rd_ok | input | 1 | Fine-grained read allow bit (0 traps) |
| fgt_wr_ok | input | 1 | Fine-grained write allow bit (0 traps) |
| l2_own_lo | input | 1 | Low bit of level-2 trace ownership (0 traps) |
| os_lock | input | 1 | OS lock set |
| halt_ok | input | 1 | Halting is allowed |
| trace_acc_trap | input | 1 | Debug trap-on-trace-access control |
| el1_narrow | input | 1 | Level 1 runs in the 32-bit state |
| rsp_valid | output | 1 | Decision valid |
| rsp_outcome | output | 5 | One-hot decision |
| rsp_class | output | 6 | Exception class of a trap |

## Verification
The hardest situations to reach are those where several conditions are true at once, because each input alone only ever moves one result. The stimulus sets up a baseline that permits the access and then switches on a stack of conflicting conditions. It removes them one at a time, so that every step in the level-1 chain is seen to beat the step below it. A long pseudo-random sweep follows, with the level, direction, straps and control bits all drawn per request, and each decision is compared against a separately written reference chain.

// File: rtl/sra_pkg.sv
package sra_pkg;

  localparam int unsigned RESULT_N = 5;

  typedef enum logic [2:0] {
    RES_PERMIT = 3'd0,
    RES_UNDEF  = 3'd1,
    RES_TRAP2  = 3'd2,
    RES_TRAP3  = 3'd3,
    RES_HALT   = 3'd4
  } result_e;

  typedef struct packed {
    logic tb_off;     // level-3 trace access disabled
    logic own_bad;    // ownership mismatch against current state
    logic fgt_hit;    // fine-grained trap to level 2
    logic l2_hit;     // level-2 ownership trap
    logic halt_any;   // halt condition without the width qualifier
    logic halt_wide;  // halt condition with level 1 in 64-bit state
  } cond_t;

endpackage

// File: rtl/sra_rst_sync.sv
module sra_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sra_cond.sv
module sra_cond
  import sra_pkg::*;
(
  input  logic       req_write,
  input  logic       strap_el3,
  input  logic       strap_el2_on,
  input  logic       strap_fgt,
  input  logic       strap_realm,
  input  logic       strap_ext_trace,
  input  logic       l3_trace_en,
  input  logic [1:0] l3_owner,
  input  logic       l3_realm_owner,
  input  logic       cur_ns,
  input  logic       cur_realm,
  input  logic       l3_fgt_en,
  input  logic       fgt_rd_ok,
  input  logic       fgt_wr_ok,
  input  logic       l2_own_lo,
  input  logic       os_lock,
  input  logic       halt_ok,
  input  logic       trace_acc_trap,
  input  logic       el1_narrow,
  output cond_t      cond
);
  logic mismatch;
  logic allow_bit;

  always_comb begin
    mismatch  = !l3_owner[0]
              || (l3_owner[1] != cur_ns)
              || (strap_realm && (l3_realm_owner != cur_realm));
    allow_bit = req_write ? fgt_wr_ok : fgt_rd_ok;

    cond.tb_off    = strap_el3 && !l3_trace_en;
    cond.own_bad   = strap_el3 && mismatch;
    cond.fgt_hit   = strap_el2_on && strap_fgt
                   && ((strap_el3 && !l3_fgt_en) || !allow_bit);
    cond.l2_hit    = strap_el2_on && !l2_own_lo;
    cond.halt_any  = strap_ext_trace && !os_lock && halt_ok && trace_acc_trap;
    cond.halt_wide = cond.halt_any && !el1_narrow;
  end
endmodule

// File: rtl/sra_prio.sv
module sra_prio
  import sra_pkg::*;
(
  input  logic [1:0] req_el,
  input  cond_t      cond,
  input  logic       sdd_early,
  input  logic       sdd_undef,
  output result_e    result
);
  result_e l3_res;

  always_comb begin
    l3_res = sdd_undef ? RES_UNDEF : RES_TRAP3;
    case (req_el)
      2'd0: result = RES_UNDEF;
      2'd1: begin
        if      (sdd_early && cond.tb_off)  result = RES_UNDEF;
        else if (sdd_early && cond.own_bad) result = RES_UNDEF;
        else if (cond.fgt_hit)              result = RES_TRAP2;
        else if (cond.l2_hit)               result = RES_TRAP2;
        else if (cond.tb_off)               result = l3_res;
        else if (cond.own_bad)              result = l3_res;
        else if (cond.halt_any)             result = RES_HALT;
        else                                result = RES_PERMIT;
      end
      2'd2: begin
        if      (sdd_early && cond.own_bad) result = RES_UNDEF;
        else if (sdd_early && cond.tb_off)  result = RES_UNDEF;
        else if (cond.own_bad)              result = l3_res;
        else if (cond.tb_off)               result = l3_res;
        else if (cond.halt_wide)            result = RES_HALT;
        else                                result = RES_PERMIT;
      end
      default: result = cond.halt_wide ? RES_HALT : RES_PERMIT;
    endcase
  end
endmodule

// File: rtl/sra_resp_reg.sv
module sra_resp_reg
  import sra_pkg::*;
#(
  parameter int unsigned       OUT_W    = RESULT_N,
  parameter int unsigned       CLS_W    = 6,
  parameter logic [CLS_W-1:0]  TRAP_CLS = 6'h18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  result_e          result,
  output logic             rsp_valid,
  output logic [OUT_W-1:0] rsp_outcome,
  output logic [CLS_W-1:0] rsp_class
);
  logic [OUT_W-1:0] onehot;
  logic             valid_d;
  logic [OUT_W-1:0] outcome_d;
  logic [CLS_W-1:0] class_d;
  logic             load_en;

  for (genvar gi = 0; gi < OUT_W; gi++) begin : g_onehot
    assign onehot[gi] = (result == result_e'(gi));
  end

  always_comb begin
    load_en   = req_valid || rsp_valid;
    valid_d   = req_valid;
    outcome_d = req_valid ? onehot : '0;
    class_d   = (req_valid && (result == RES_TRAP2 || result == RES_TRAP3))
              ? TRAP_CLS : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_outcome <= '0;
      rsp_class   <= '0;
    end else if (load_en) begin
      rsp_valid   <= valid_d;
      rsp_outcome <= outcome_d;
      rsp_class   <= class_d;
    end
  end
endmodule

// File: rtl/sysreg_access_arbiter.sv
module sysreg_access_arbiter
  import sra_pkg::*;
#(
  parameter int unsigned      OUT_W      = RESULT_N,
  parameter int unsigned      CLS_W      = 6,
  parameter logic [CLS_W-1:0] TRAP_CLS   = 6'h18,
  parameter int unsigned      SYNC_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_el,
  input  logic             strap_el3,
  input  logic             strap_el2_on,
  input  logic             strap_fgt,
  input  logic             strap_realm,
  input  logic             strap_ext_trace,
  input  logic             sdd_early,
  input  logic             sdd_undef,
  input  logic             l3_trace_en,
  input  logic [1:0]       l3_owner,
  input  logic             l3_realm_owner,
  input  logic             cur_ns,
  input  logic             cur_realm,
  input  logic             l3_fgt_en,
  input  logic             fgt_rd_ok,
  input  logic             fgt_wr_ok,
  input  logic             l2_own_lo,
  input  logic             os_lock,
  input  logic             halt_ok,
  input  logic             trace_acc_trap,
  input  logic             el1_narrow,
  output logic             rsp_valid,
  output logic [OUT_W-1:0] rsp_outcome,
  output logic [CLS_W-1:0] rsp_class
);
  logic    rst_sync_n;
  cond_t   cond;
  result_e result;

  sra_rst_sync #(.STAGES(SYNC_STAGE)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sra_cond i_cond (
    .req_write       (req_write),
    .strap_el3       (strap_el3),
    .strap_el2_on    (strap_el2_on),
    .strap_fgt       (strap_fgt),
    .strap_realm     (strap_realm),
    .strap_ext_trace (strap_ext_trace),
    .l3_trace_en     (l3_trace_en),
    .l3_owner        (l3_owner),
    .l3_realm_owner  (l3_realm_owner),
    .cur_ns          (cur_ns),
    .cur_realm       (cur_realm),
    .l3_fgt_en       (l3_fgt_en),
    .fgt_rd_ok       (fgt_rd_ok),
    .fgt_wr_ok       (fgt_wr_ok),
    .l2_own_lo       (l2_own_lo),
    .os_lock         (os_lock),
    .halt_ok         (halt_ok),
    .trace_acc_trap  (trace_acc_trap),
    .el1_narrow      (el1_narrow),
    .cond            (cond)
  );

  sra_prio i_prio (
    .req_el    (req_el),
    .cond      (cond),
    .sdd_early (sdd_early),
    .sdd_undef (sdd_undef),
    .result    (result)
  );

  sra_resp_reg #(
    .OUT_W    (OUT_W),
    .CLS_W    (CLS_W),
    .TRAP_CLS (TRAP_CLS)
  ) i_resp (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid   (req_valid),
    .result      (result),
    .rsp_valid   (rsp_valid),
    .rsp_outcome (rsp_outcome),
    .rsp_class   (rsp_class)
  );
endmodule

// File: rtl/sra_chk.sv
module sra_chk #(
  parameter int unsigned      OUT_W    = 5,
  parameter int unsigned      CLS_W    = 6,
  parameter logic [CLS_W-1:0] TRAP_CLS = 6'h18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_el,
  input logic             rsp_valid,
  input logic [OUT_W-1:0] rsp_outcome,
  input logic [CLS_W-1:0] rsp_class
);
  logic       prev_valid;
  logic [1:0] prev_el;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_valid <= 1'b0;
      prev_el    <= 2'd0;
    end else begin
      prev_valid <= req_valid;
      prev_el    <= req_el;
    end
  end

  a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == prev_valid);

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_outcome == '0 && rsp_class == '0));

  a_r3_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(rsp_outcome) == 1);

  a_r4_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_class == TRAP_CLS) == (rsp_outcome[2] || rsp_outcome[3])));

  a_r1_level0_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && prev_el == 2'd0) |-> rsp_outcome[1]);

  a_r8_no_l2_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && prev_el == 2'd2) |-> !rsp_outcome[2]);

  a_r11_level3_only: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && prev_el == 2'd3) |-> (rsp_outcome[0] || rsp_outcome[4]));
endmodule

bind sysreg_access_arbiter sra_chk #(
  .OUT_W    (OUT_W),
  .CLS_W    (CLS_W),
  .TRAP_CLS (TRAP_CLS)
) i_sra_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .req_valid   (req_valid),
  .req_el      (req_el),
  .rsp_valid   (rsp_valid),
  .rsp_outcome (rsp_outcome),
  .rsp_class   (rsp_class)
);

// File: tb/test_sysreg_access_arbiter.sv
`timescale 1ns/1ps
module test_sysreg_access_arbiter;
  localparam logic [4:0] B_PERMIT = 5'b00001;
  localparam logic [4:0] B_UNDEF  = 5'b00010;
  localparam logic [4:0] B_TRAP2  = 5'b00100;
  localparam logic [4:0] B_TRAP3  = 5'b01000;
  localparam logic [4:0] B_HALT   = 5'b10000;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [1:0] req_el;
  logic strap_el3, strap_el2_on, strap_fgt, strap_realm, strap_ext_trace;
  logic sdd_early, sdd_undef, l3_trace_en;
  logic [1:0] l3_owner;
  logic l3_realm_owner, cur_ns, cur_realm, l3_fgt_en, fgt_rd_ok, fgt_wr_ok;
  logic l2_own_lo, os_lock, halt_ok, trace_acc_trap, el1_narrow;
  logic rsp_valid;
  logic [4:0] rsp_outcome;
  logic [5:0] rsp_class;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sysreg_access_arbiter i_sysreg_access_arbiter (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_base();
    strap_el3 = 1; strap_el2_on = 1; strap_fgt = 1; strap_realm = 1; strap_ext_trace = 1;
    sdd_early = 0; sdd_undef = 0; l3_trace_en = 1; l3_owner = 2'b11;
    l3_realm_owner = 0; cur_ns = 1; cur_realm = 0; l3_fgt_en = 1;
    fgt_rd_ok = 1; fgt_wr_ok = 1; l2_own_lo = 1;
    os_lock = 1; halt_ok = 1; trace_acc_trap = 0; el1_narrow = 0;
  endtask

  // Independent reference chain
  function automatic logic [4:0] ref_model(input logic wr, input logic [1:0] el);
    logic mm, tboff, own, fg, l2, h1, hw;
    logic [4:0] t3;
    mm = (l3_owner[0] == 1'b0) || (l3_owner[1] != cur_ns) ||
         (strap_realm == 1'b1 && l3_realm_owner != cur_realm);
    own   = strap_el3 && mm;
    tboff = strap_el3 && !l3_trace_en;
    fg = strap_el2_on && strap_fgt &&
         ((strap_el3 && !l3_fgt_en) || (wr ? !fgt_wr_ok : !fgt_rd_ok));
    l2 = strap_el2_on && !l2_own_lo;
    h1 = strap_ext_trace && !os_lock && halt_ok && trace_acc_trap;
    hw = h1 && !el1_narrow;
    t3 = sdd_undef ? B_UNDEF : B_TRAP3;
    if (el == 2'd0) return B_UNDEF;
    if (el == 2'd3) return hw ? B_HALT : B_PERMIT;
    if (el == 2'd1) begin
      if (sdd_early && (tboff || own)) return B_UNDEF;
      if (fg || l2) return B_TRAP2;
      if (tboff || own) return t3;
      return h1 ? B_HALT : B_PERMIT;
    end
    if (sdd_early && (own || tboff)) return B_UNDEF;
    if (own || tboff) return t3;
    return hw ? B_HALT : B_PERMIT;
  endfunction

  task automatic send(input logic wr, input logic [1:0] el, input logic [4:0] exp, input string tag);
    @(negedge clk);
    req_write = wr; req_el = el; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " outcome"}, 32'(rsp_outcome), 32'(exp));
    check({tag, " R4 class"}, 32'(rsp_class),
          (exp == B_TRAP2 || exp == B_TRAP3) ? 32'h18 : 32'h0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_el = 2'd1;
    set_base();
    repeat (3) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    check("R12 reset valid", 32'(rsp_valid), 32'd0);
    check("R12 reset outcome", 32'(rsp_outcome), 32'd0);
    check("R12 reset class", 32'(rsp_class), 32'd0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_level0();
    set_base();
    send(1'b0, 2'd0, B_UNDEF, "R1 level0 read");
    sdd_undef = 1; os_lock = 0; trace_acc_trap = 1;
    send(1'b1, 2'd0, B_UNDEF, "R1 level0 write");
  endtask

  task automatic t_idle();
    set_base();
    send(1'b0, 2'd1, B_PERMIT, "R2 baseline");
    @(negedge clk);
    check("R2 idle valid", 32'(rsp_valid), 32'd0);
    check("R2 idle outcome", 32'(rsp_outcome), 32'd0);
  endtask

  task automatic t_level1_order();
    set_base();
    l3_trace_en = 0; sdd_early = 1; fgt_rd_ok = 0; l2_own_lo = 0;
    os_lock = 0; trace_acc_trap = 1;
    send(1'b0, 2'd1, B_UNDEF, "R6 early undef first");
    sdd_early = 0;
    send(1'b0, 2'd1, B_TRAP2, "R6 fgt over l3");
    fgt_rd_ok = 1;
    send(1'b0, 2'd1, B_TRAP2, "R6 l2 trap");
    l2_own_lo = 1;
    send(1'b0, 2'd1, B_TRAP3, "R6 l3 trap over halt");
    l3_trace_en = 1;
    send(1'b0, 2'd1, B_HALT, "R10 level1 halt");
    el1_narrow = 1;
    send(1'b0, 2'd1, B_HALT, "R10 level1 ignores narrow");
  endtask

  task automatic t_rw_split();
    set_base();
    fgt_rd_ok = 0;
    send(1'b1, 2'd1, B_PERMIT, "R7 write uses write bit");
    send(1'b0, 2'd1, B_TRAP2, "R7 read uses read bit");
    fgt_rd_ok = 1; l3_fgt_en = 0;
    send(1'b1, 2'd1, B_TRAP2, "R7 l3 fgt enable off");
    strap_fgt = 0;
    send(1'b1, 2'd1, B_PERMIT, "R7 no fgt feature");
  endtask

  task automatic t_owner();
    set_base();
    l3_owner = 2'b10;
    send(1'b0, 2'd1, B_TRAP3, "R5 owner bit0 clear");
    l3_owner = 2'b11; cur_ns = 0;
    send(1'b0, 2'd1, B_TRAP3, "R5 owner ns differs");
    cur_ns = 1; cur_realm = 1;
    send(1'b0, 2'd1, B_TRAP3, "R5 realm differs");
    strap_realm = 0;
    send(1'b0, 2'd1, B_PERMIT, "R5 realm absent");
    strap_el3 = 0; l3_owner = 2'b00;
    send(1'b0, 2'd1, B_PERMIT, "R5 no level3");
  endtask

  task automatic t_level2();
    set_base();
    fgt_rd_ok = 0; l2_own_lo = 0;
    send(1'b0, 2'd2, B_PERMIT, "R8 no l2 traps at level2");
    l3_owner = 2'b01;
    send(1'b0, 2'd2, B_TRAP3, "R8 mismatch trap");
    sdd_early = 1;
    send(1'b0, 2'd2, B_UNDEF, "R8 early mismatch undef");
  endtask

  task automatic t_sdd();
    set_base();
    l3_trace_en = 0; sdd_undef = 1;
    send(1'b0, 2'd1, B_UNDEF, "R9 level1 trap to undef");
    send(1'b1, 2'd2, B_UNDEF, "R9 level2 trap to undef");
    strap_el3 = 0;
    send(1'b0, 2'd1, B_PERMIT, "R9 no level3");
  endtask

  task automatic t_halt_hi();
    set_base();
    os_lock = 0; trace_acc_trap = 1;
    send(1'b0, 2'd2, B_HALT, "R10 level2 halt");
    el1_narrow = 1;
    send(1'b0, 2'd2, B_PERMIT, "R10 level2 narrow blocks");
    el1_narrow = 0; halt_ok = 0;
    send(1'b0, 2'd2, B_PERMIT, "R10 halt not allowed");
  endtask

  task automatic t_level3();
    set_base();
    l3_trace_en = 0; l3_owner = 2'b00; fgt_rd_ok = 0; l2_own_lo = 0; sdd_early = 1;
    send(1'b0, 2'd3, B_PERMIT, "R11 level3 ignores traps");
    os_lock = 0; trace_acc_trap = 1;
    send(1'b1, 2'd3, B_HALT, "R11 level3 halt");
    el1_narrow = 1;
    send(1'b1, 2'd3, B_PERMIT, "R11 level3 narrow blocks halt");
  endtask

  task automatic t_sweep();
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      logic wr;
      logic [1:0] el;
      r = $urandom();
      {strap_el3, strap_el2_on, strap_fgt, strap_realm, strap_ext_trace,
       sdd_early, sdd_undef, l3_trace_en, l3_owner, l3_realm_owner, cur_ns,
       cur_realm, l3_fgt_en, fgt_rd_ok, fgt_wr_ok, l2_own_lo, os_lock,
       halt_ok, trace_acc_trap, el1_narrow, wr, el} = r[23:0];
      send(wr, el, ref_model(wr, el), "R3 sweep");
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    t_reset();
    t_level0();
    t_idle();
    t_level1_order();
    t_rw_split();
    t_owner();
    t_level2();
    t_sdd();
    t_halt_hi();
    t_level3();
    t_sweep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule